// File: doc/BRIEF.md
# Buffered Program Load Sequencer

This block sits behind the command decoder of a flash-style memory controller. It accepts the bus writes that fill a small staging buffer before a buffered program operation. A sequence opens with a setup write that names the target block. A count write follows, then the data writes, then a confirm write. The data are captured into a 32-byte buffer. After a valid confirm, the block hands the buffer to an external program engine through a one-cycle start pulse, and it holds a busy level until the engine answers with done. The engine reads the staged bytes through a random-access read port.

The block keeps three sticky error flags: program, erase and lock. While the program or erase flag is set, it refuses new setup commands. An extended status byte reports whether a buffer can be taken. Every write is sampled on a rising clock edge while `wr_en` is high. Command codes are compared on the low data byte only. The count value is compared on the full data word.

Top module: `bufwr_loader`

## Requirements
- R1: From idle, a write whose low byte is E8h starts a sequence, provided neither the program nor the erase error flag is set. The target block is taken from address bits [22:16] of that write, and the buffer width is taken from `byte_mode` (1 gives byte entries, 0 gives 16-bit entries). Any other low byte in idle, apart from 50h, has no effect.
- R2: The write after the setup carries the count N. Exactly N+1 data writes are then accepted. N may be 0 to 31 in byte mode and 0 to 15 in word mode.
- R3: A count above the limit for the mode sets both the erase and the program error flags, and the block returns to idle.
- R4: In byte mode, data write k stores data[7:0] at buffer byte k. In word mode, data write k stores data[7:0] at byte 2k and data[15:8] at byte 2k+1. `eng_byte` returns the byte selected by `eng_idx`.
- R5: A write with low byte D0h in the slot after the last data write starts programming. In the following cycle `prog_start` is high for exactly one cycle, `prog_base` holds the address of the first data write, `prog_cnt` holds N, and `prog_wide` holds 1 for word mode.
- R6: Any other value in the confirm slot aborts the sequence. No start pulse follows, and no flag changes.
- R7: `xsr` bit 7 reads 1 whenever the block is not busy and 0 while it is busy. Bits 6 to 0 always read 0.
- R8: While the program or erase error flag is set, a setup write is refused, and the count, data and confirm writes after it start nothing.
- R9: If the lock bit of the target block is set when D0h confirms, the program and lock error flags are set, no start pulse is issued, and the block returns to idle.
- R10: A data write whose block bits differ from the setup block sets the program error flag and returns the block to idle. A later D0h then starts nothing.
- R11: `busy` is high from the cycle after a valid confirm until the cycle after `prog_done` is sampled. Bus writes made while busy are ignored.
- R12: A write with low byte 50h in idle clears all three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 23 | Bus write address; bits [22:16] select the block |
| wr_data | input | 16 | Bus write data |
| byte_mode | input | 1 | Buffer width selected at setup: 1 = bytes, 0 = words |
| lock_vec | input | 128 | Per-block lock bits |
| prog_done | input | 1 | Program engine completion |
| eng_idx | input | 5 | Buffer byte index read by the engine |
| eng_byte | output | 8 | Buffer byte at `eng_idx` |
| prog_start | output | 1 | One-cycle start pulse to the engine |
| prog_base | output | 23 | Address of the first data write |
| prog_cnt | output | 5 | Count argument N of the loaded sequence |
| prog_wide | output | 1 | 1 when the sequence was loaded in word mode |
| busy | output | 1 | Program operation in flight |
| xsr | output | 8 | Extended status; bit 7 = buffer available |
| err_pgm | output | 1 | Sticky program error flag |
| err_ers | output | 1 | Sticky erase error flag |
| err_lock | output | 1 | Sticky lock error flag |

## Verification
The load path is exercised with short and maximum-length counts in both widths. Word-mode data carry distinct upper and lower bytes, so a swapped or dropped half of a word shows up in the engine readback. Faulty sequences are run one at a time: an over-limit count in each mode, a wrong confirm code, an address outside the block, and a locked block. Each one drives a different combination of flags and start pulses. Further patterns check that setup is refused while the program or erase flag is set, that a clear write lifts the refusal, and that writes sent while busy or without a setup start nothing.

// File: rtl/bufwr_pkg.sv
package bufwr_pkg;
   typedef enum logic [2:0] {
      LD_IDLE,
      LD_COUNT,
      LD_DATA,
      LD_CONF,
      LD_BUSY
   } ld_state_t;

   localparam logic [7:0] CMD_SETUP   = 8'hE8;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;
   localparam logic [7:0] CMD_CLEAR   = 8'h50;
endpackage

// File: rtl/bufwr_store.sv
module bufwr_store #(
   parameter int BUF_BYTES = 32,
   parameter int DATA_W    = 16,
   localparam int IDX_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wide,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_byte
);
   logic [7:0] bytes_q [BUF_BYTES];

   for (genvar j = 0; j < BUF_BYTES; j++) begin : g_byte
      localparam logic [IDX_W-1:0] SELF = IDX_W'(j);
      localparam logic [IDX_W-1:0] PAIR = IDX_W'(j / 2);
      logic hit;
      logic [7:0] src;
      always_comb begin
         hit = wide ? (idx == PAIR) : (idx == SELF);
         if (wide && (j % 2 == 1)) src = wdata[15:8];
         else                      src = wdata[7:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         bytes_q[j] <= '0;
         else if (we && hit) bytes_q[j] <= src;
      end
   end

   assign rd_byte = bytes_q[rd_idx];
endmodule

// File: rtl/bufwr_flags.sv
module bufwr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pgm,
   input  logic set_ers,
   input  logic set_lock,
   input  logic clr,
   output logic err_pgm,
   output logic err_ers,
   output logic err_lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pgm  <= 1'b0;
         err_ers  <= 1'b0;
         err_lock <= 1'b0;
      end else begin
         if (set_pgm)       err_pgm  <= 1'b1;
         else if (clr)      err_pgm  <= 1'b0;
         if (set_ers)       err_ers  <= 1'b1;
         else if (clr)      err_ers  <= 1'b0;
         if (set_lock)      err_lock <= 1'b1;
         else if (clr)      err_lock <= 1'b0;
      end
   end

   // R12: a clear empties every flag
   a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!err_pgm && !err_ers && !err_lock));
   // R9: the lock flag stays until cleared
   a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_lock && !clr) |=> err_lock);
endmodule

// File: rtl/bufwr_ctl.sv
module bufwr_ctl
   import bufwr_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int DATA_W    = 16,
   parameter int BLK_LSB   = 16,
   parameter int BUF_BYTES = 32,
   localparam int BLK_W    = ADDR_W - BLK_LSB,
   localparam int NUM_BLK  = 1 << BLK_W,
   localparam int IDX_W    = $clog2(BUF_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               byte_mode,
   input  logic [NUM_BLK-1:0] lock_vec,
   input  logic               prog_done,
   input  logic               err_block,
   output logic               st_we,
   output logic [IDX_W-1:0]   st_idx,
   output logic               st_wide,
   output logic               set_pgm,
   output logic               set_ers,
   output logic               set_lock,
   output logic               clr,
   output logic               prog_start,
   output logic [ADDR_W-1:0]  prog_base,
   output logic [IDX_W-1:0]   prog_cnt,
   output logic               busy
);
   localparam logic [DATA_W-1:0] LIM_BYTE = DATA_W'(BUF_BYTES - 1);
   localparam logic [DATA_W-1:0] LIM_WORD = DATA_W'(BUF_BYTES / 2 - 1);

   ld_state_t          state_q, state_d;
   logic [BLK_W-1:0]   blk_q;
   logic               wide_q;
   logic [IDX_W-1:0]   cnt_q, idx_q;
   logic [ADDR_W-1:0]  base_q;
   logic               start_q;
   logic [7:0]         code;
   logic               over, in_blk, locked, go;

   assign code   = wr_data[7:0];
   assign over   = wide_q ? (wr_data > LIM_WORD) : (wr_data > LIM_BYTE);
   assign in_blk = (wr_addr[ADDR_W-1:BLK_LSB] == blk_q);
   assign locked = lock_vec[blk_q];

   always_comb begin
      state_d  = state_q;
      set_pgm  = 1'b0;
      set_ers  = 1'b0;
      set_lock = 1'b0;
      clr      = 1'b0;
      st_we    = 1'b0;
      go       = 1'b0;
      unique case (state_q)
         LD_IDLE: if (wr_en) begin
            if (code == CMD_SETUP && !err_block) state_d = LD_COUNT;
            else if (code == CMD_CLEAR)          clr = 1'b1;
         end
         LD_COUNT: if (wr_en) begin
            if (over) begin
               set_pgm = 1'b1;
               set_ers = 1'b1;
               state_d = LD_IDLE;
            end else begin
               state_d = LD_DATA;
            end
         end
         LD_DATA: if (wr_en) begin
            if (!in_blk) begin
               set_pgm = 1'b1;
               state_d = LD_IDLE;
            end else begin
               st_we = 1'b1;
               if (idx_q == cnt_q) state_d = LD_CONF;
            end
         end
         LD_CONF: if (wr_en) begin
            if (code == CMD_CONFIRM && locked) begin
               set_pgm  = 1'b1;
               set_lock = 1'b1;
               state_d  = LD_IDLE;
            end else if (code == CMD_CONFIRM) begin
               go      = 1'b1;
               state_d = LD_BUSY;
            end else begin
               state_d = LD_IDLE;
            end
         end
         LD_BUSY: if (prog_done) state_d = LD_IDLE;
         default: state_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         blk_q   <= '0;
         wide_q  <= 1'b0;
         cnt_q   <= '0;
         idx_q   <= '0;
         base_q  <= '0;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= go;
         if (state_q == LD_IDLE && state_d == LD_COUNT) begin
            blk_q  <= wr_addr[ADDR_W-1:BLK_LSB];
            wide_q <= !byte_mode;
         end
         if (state_q == LD_COUNT && state_d == LD_DATA) begin
            cnt_q <= wr_data[IDX_W-1:0];
            idx_q <= '0;
         end
         if (st_we) begin
            if (idx_q == '0) base_q <= wr_addr;
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign st_idx     = idx_q;
   assign st_wide    = wide_q;
   assign prog_start = start_q;
   assign prog_base  = base_q;
   assign prog_cnt   = cnt_q;
   assign busy       = (state_q == LD_BUSY);

   // R8: setup is refused while an error flag blocks it
   a_r8_refuse_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_IDLE && wr_en && err_block) |=> (state_q == LD_IDLE));
   // R3: an over-limit count flags a bad sequence and goes idle
   a_r3_over_count: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_COUNT && wr_en && over) |=> (state_q == LD_IDLE));
   // R10: a write outside the block ends the load
   a_r10_outside_block: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_DATA && wr_en && !in_blk) |=> (state_q == LD_IDLE && !prog_start));
   // R6: a wrong confirm code never starts programming
   a_r6_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_CONF && wr_en && code != CMD_CONFIRM) |=> (!prog_start && !busy));
   // R2: the confirm slot is reached only after the counted writes
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_DATA) |-> (idx_q <= cnt_q));
endmodule

// File: rtl/bufwr_loader.sv
module bufwr_loader
   import bufwr_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int DATA_W    = 16,
   parameter int BLK_LSB   = 16,
   parameter int BUF_BYTES = 32,
   localparam int BLK_W    = ADDR_W - BLK_LSB,
   localparam int NUM_BLK  = 1 << BLK_W,
   localparam int IDX_W    = $clog2(BUF_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               byte_mode,
   input  logic [NUM_BLK-1:0] lock_vec,
   input  logic               prog_done,
   input  logic [IDX_W-1:0]   eng_idx,
   output logic [7:0]         eng_byte,
   output logic               prog_start,
   output logic [ADDR_W-1:0]  prog_base,
   output logic [IDX_W-1:0]   prog_cnt,
   output logic               prog_wide,
   output logic               busy,
   output logic [7:0]         xsr,
   output logic               err_pgm,
   output logic               err_ers,
   output logic               err_lock
);
   if (DATA_W != 16) begin : g_bad_data
      $error("bufwr_loader: DATA_W must be 16");
   end
   if (BUF_BYTES < 4 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("bufwr_loader: BUF_BYTES must be a power of two of at least 4");
   end
   if (BLK_W < 1 || BLK_W > 12) begin : g_bad_blk
      $error("bufwr_loader: block field width out of range");
   end

   logic             st_we, st_wide;
   logic [IDX_W-1:0] st_idx;
   logic             set_pgm, set_ers, set_lock, clr;

   bufwr_ctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LSB(BLK_LSB), .BUF_BYTES(BUF_BYTES)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .byte_mode(byte_mode), .lock_vec(lock_vec),
      .prog_done(prog_done), .err_block(err_pgm | err_ers),
      .st_we(st_we), .st_idx(st_idx), .st_wide(st_wide),
      .set_pgm(set_pgm), .set_ers(set_ers), .set_lock(set_lock), .clr(clr),
      .prog_start(prog_start), .prog_base(prog_base), .prog_cnt(prog_cnt),
      .busy(busy)
   );

   bufwr_store #(.BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(st_we), .wide(st_wide), .idx(st_idx),
      .wdata(wr_data), .rd_idx(eng_idx), .rd_byte(eng_byte)
   );

   bufwr_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set_pgm(set_pgm), .set_ers(set_ers),
      .set_lock(set_lock), .clr(clr),
      .err_pgm(err_pgm), .err_ers(err_ers), .err_lock(err_lock)
   );

   assign prog_wide = st_wide;
   assign xsr       = {~busy, 7'b0};

   // R5: the start pulse lasts one cycle and lands in the busy phase
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);
   a_r11_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> busy);
   // R11: done releases busy on the next cycle
   a_r11_done_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && prog_done) |=> !busy);
   // R11: busy only rises together with a start pulse
   a_r11_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> prog_start);
endmodule

// File: tb/tb_bufwr_loader.sv
`timescale 1ns/1ps
module tb_bufwr_loader;
   localparam int CLK_PERIOD = 10;
   localparam int ENG_LAT    = 12;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [22:0]  wr_addr;
   logic [15:0]  wr_data;
   logic         byte_mode;
   logic [127:0] lock_vec;
   logic         prog_done;
   logic [4:0]   eng_idx;
   logic [7:0]   eng_byte;
   logic         prog_start;
   logic [22:0]  prog_base;
   logic [4:0]   prog_cnt;
   logic         prog_wide;
   logic         busy;
   logic [7:0]   xsr;
   logic         err_pgm, err_ers, err_lock;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bufwr_loader dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .byte_mode(byte_mode), .lock_vec(lock_vec),
      .prog_done(prog_done), .eng_idx(eng_idx), .eng_byte(eng_byte),
      .prog_start(prog_start), .prog_base(prog_base), .prog_cnt(prog_cnt),
      .prog_wide(prog_wide), .busy(busy), .xsr(xsr),
      .err_pgm(err_pgm), .err_ers(err_ers), .err_lock(err_lock)
   );

   int tests = 0, fails = 0, starts = 0;
   bit summary_done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
      end
   endtask

   // behavioural reference: 0 idle, 1 count, 2 data, 3 confirm, 4 busy
   int       m_st, m_blk, m_n, m_i, m_base;
   bit       m_wide, m_pgm, m_ers, m_lock, m_start;
   bit [7:0] m_buf [32];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_blk = 0; m_n = 0; m_i = 0; m_base = 0; m_wide = 0;
         m_pgm = 0; m_ers = 0; m_lock = 0; m_start = 0;
      end else begin
         m_start = 0;
         case (m_st)
            0: if (wr_en) begin
               if (wr_data[7:0] == 8'hE8 && !(m_pgm || m_ers)) begin
                  m_st = 1; m_blk = int'(wr_addr[22:16]); m_wide = !byte_mode;
               end else if (wr_data[7:0] == 8'h50) begin
                  m_pgm = 0; m_ers = 0; m_lock = 0;
               end
            end
            1: if (wr_en) begin
               if (int'(wr_data) > (m_wide ? 15 : 31)) begin
                  m_pgm = 1; m_ers = 1; m_st = 0;
               end else begin
                  m_n = int'(wr_data); m_i = 0; m_st = 2;
               end
            end
            2: if (wr_en) begin
               if (int'(wr_addr[22:16]) != m_blk) begin
                  m_pgm = 1; m_st = 0;
               end else begin
                  if (m_wide) begin
                     m_buf[2*m_i]   = wr_data[7:0];
                     m_buf[2*m_i+1] = wr_data[15:8];
                  end else begin
                     m_buf[m_i] = wr_data[7:0];
                  end
                  if (m_i == 0) m_base = int'(wr_addr);
                  if (m_i == m_n) m_st = 3;
                  else m_i++;
               end
            end
            3: if (wr_en) begin
               if (wr_data[7:0] == 8'hD0) begin
                  if (lock_vec[m_blk]) begin
                     m_pgm = 1; m_lock = 1; m_st = 0;
                  end else begin
                     m_st = 4; m_start = 1;
                  end
               end else begin
                  m_st = 0;
               end
            end
            default: if (prog_done) m_st = 0;
         endcase
      end
   end

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (m_st == 4), "R11 busy", busy, (m_st == 4));
         chk(prog_start == m_start, "R5 prog_start", prog_start, m_start);
         chk(xsr == {(m_st != 4), 7'b0}, "R7 xsr", xsr, {(m_st != 4), 7'b0});
         chk(err_pgm == m_pgm, "R10 err_pgm", err_pgm, m_pgm);
         chk(err_ers == m_ers, "R3 err_ers", err_ers, m_ers);
         chk(err_lock == m_lock, "R9 err_lock", err_lock, m_lock);
      end
   end

   // program engine model: reads the buffer, then answers after a fixed delay
   initial begin
      prog_done = 1'b0;
      eng_idx   = '0;
      forever begin
         @(negedge clk);
         if (rst_n && prog_start) begin
            int nb;
            starts++;
            chk(int'(prog_base) == m_base, "R5 prog_base", prog_base, m_base);
            chk(int'(prog_cnt) == m_n, "R5 prog_cnt", prog_cnt, m_n);
            chk(prog_wide == m_wide, "R5 prog_wide", prog_wide, m_wide);
            nb = m_wide ? 2 * (m_n + 1) : m_n + 1;
            for (int k = 0; k < nb; k++) begin
               @(negedge clk);
               eng_idx = 5'(k);
               #1;
               chk(eng_byte == m_buf[k], "R4 buffer byte", eng_byte, m_buf[k]);
            end
            repeat (ENG_LAT) @(negedge clk);
            prog_done = 1'b1;
            @(negedge clk);
            prog_done = 1'b0;
         end
      end
   end

   task automatic bus_wr(input logic [22:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input int blk, input bit bm, input int n, input int nwr, input int seed);
      byte_mode = bm;
      bus_wr({7'(blk), 16'h0000}, 16'h00E8);
      bus_wr({7'(blk), 16'h0000}, 16'(n));
      for (int k = 0; k < nwr; k++)
         bus_wr({7'(blk), 16'(16'h0200 + k)}, 16'(seed + k * 16'h0113));
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int s0;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      byte_mode = 1'b1; lock_vec = '0;
      repeat (3) @(negedge clk);
      chk(xsr == 8'h80, "R7 reset xsr", xsr, 8'h80);
      chk(!busy && !prog_start, "R11 reset busy", busy, 0);
      chk(!err_pgm && !err_ers && !err_lock, "R12 reset flags", {err_pgm, err_ers, err_lock}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R5: short byte-mode load
      s0 = starts;
      load(5, 1, 3, 4, 16'h1A2B);
      bus_wr('0, 16'h00D0);
      chk(busy && xsr == 8'h00, "R7 busy xsr", xsr, 8'h00);
      wait_idle();
      chk(starts == s0 + 1, "R1 sequence starts", starts, s0 + 1);

      // R2: largest word-mode count, both halves distinct
      s0 = starts;
      load(9, 0, 15, 16, 16'hC35A);
      bus_wr('0, 16'hFFD0);
      wait_idle();
      chk(starts == s0 + 1, "R2 word max count", starts, s0 + 1);

      // R2: largest byte-mode count in the top block
      s0 = starts;
      load(127, 1, 31, 32, 16'h0007);
      bus_wr('0, 16'h00D0);
      wait_idle();
      chk(starts == s0 + 1, "R2 byte max count", starts, s0 + 1);

      // R6: wrong confirm code aborts
      s0 = starts;
      load(2, 1, 1, 2, 16'h0044);
      bus_wr('0, 16'h0020);
      repeat (3) @(negedge clk);
      chk(starts == s0, "R6 no start", starts, s0);
      chk(!err_pgm && !err_ers, "R6 no flags", {err_pgm, err_ers}, 0);

      // R3 R8 R12: word-mode overcount, refusal, clear
      load(3, 0, 16, 0, 0);
      @(negedge clk);
      chk(err_pgm && err_ers, "R3 word overcount", {err_pgm, err_ers}, 3);
      s0 = starts;
      load(3, 1, 0, 1, 16'h0099);
      bus_wr('0, 16'h00D0);
      repeat (3) @(negedge clk);
      chk(starts == s0, "R8 setup refused", starts, s0);
      bus_wr('0, 16'h0050);
      @(negedge clk);
      chk(!err_pgm && !err_ers && !err_lock, "R12 clear", {err_pgm, err_ers, err_lock}, 0);
      load(3, 1, 0, 1, 16'h0099);
      bus_wr('0, 16'h00D0);
      wait_idle();
      chk(starts == s0 + 1, "R8 accepted after clear", starts, s0 + 1);

      // R3: byte-mode overcount
      load(8, 1, 32, 0, 0);
      @(negedge clk);
      chk(err_pgm && err_ers, "R3 byte overcount", {err_pgm, err_ers}, 3);
      bus_wr('0, 16'h0050);

      // R10: data write outside the block
      s0 = starts;
      load(4, 1, 2, 1, 16'h0011);
      bus_wr({7'd6, 16'h0201}, 16'h0022);
      bus_wr({7'd4, 16'h0202}, 16'h0033);
      bus_wr('0, 16'h00D0);
      repeat (3) @(negedge clk);
      chk(err_pgm && !err_ers, "R10 outside block", {err_pgm, err_ers}, 2);
      chk(starts == s0, "R10 no start", starts, s0);
      bus_wr('0, 16'h0050);

      // R9: locked block
      s0 = starts;
      lock_vec[7] = 1'b1;
      load(7, 1, 1, 2, 16'h0055);
      bus_wr('0, 16'h00D0);
      repeat (3) @(negedge clk);
      chk(err_pgm && err_lock, "R9 locked block", {err_pgm, err_lock}, 3);
      chk(starts == s0, "R9 no start", starts, s0);
      bus_wr('0, 16'h0050);
      lock_vec[7] = 1'b0;

      // R1: writes without a setup do nothing
      s0 = starts;
      bus_wr('0, 16'h0040);
      bus_wr('0, 16'h0000);
      bus_wr('0, 16'h00D0);
      repeat (3) @(negedge clk);
      chk(starts == s0, "R1 no setup no start", starts, s0);

      // R11: writes during busy are ignored
      s0 = starts;
      load(1, 1, 0, 1, 16'h00A5);
      bus_wr('0, 16'h00D0);
      bus_wr({7'd1, 16'h0}, 16'h00E8);
      wait_idle();
      bus_wr({7'd1, 16'h0}, 16'h0000);
      bus_wr({7'd1, 16'h0300}, 16'h005A);
      bus_wr('0, 16'h00D0);
      repeat (3) @(negedge clk);
      chk(starts == s0 + 1, "R11 busy writes ignored", starts, s0 + 1);

      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule